// File: doc/BRIEF.md
# Mantissa-Exponent Symbol Rate Generator

This block produces a one-cycle symbol-rate strobe from a reference clock. Software picks the rate with a small floating-point style pair: a mantissa M and an exponent E. On every reference cycle, a phase accumulator of ACC_W bits adds the step (2^MANT_W + M) shifted left by E. A strobe is raised each time the sum carries out of the top bit. The strobe rate is therefore fref · (2^MANT_W + M) · 2^E / 2^ACC_W. With the default widths (8-bit mantissa, 4-bit exponent, 28-bit accumulator), the multiplier spans 256 to 511. Each exponent step doubles both the rate and the finest rate step.

The step in use is held in a register. That register takes new settings only when the accumulator wraps or when the synchronous clear is applied. Settings may therefore be rewritten at any time without shortening or stretching the symbol period in progress. A consuming modem uses the strobe as its symbol enable. Software turns a target rate into M and E. When the rounded mantissa would overflow, software writes E+1 with M = 0, and this gives exactly the same step.

Top module: `symrate_gen`

## Requirements
- R1: After reset, the strobe is low and the accumulator is zero. The step register holds 2^MANT_W (M = 0, E = 0) whatever the setting inputs show, until the first wrap or clear.
- R2: With settings held from a clear, the number of strobes in the 2^ACC_W cycles after the clear edge equals (2^MANT_W + M) · 2^E.
- R3: Raising E by one, with M unchanged, doubles the strobe count over the same window.
- R4: The setting M = 0 with exponent E+1 gives the same strobe count as a mantissa of 2^MANT_W with exponent E, namely 2^(MANT_W+1) · 2^E.
- R5: The strobe is registered. It goes high for exactly one cycle, on the clock edge whose addition carries out of bit ACC_W-1, and it is never high on two consecutive cycles.
- R6: A change of M or E takes effect only at the next wrap. The wrap itself is timed by the old step, and the new step is used from the wrap edge onward.
- R7: While clear is high at a clock edge, the accumulator becomes zero, the strobe is low after that edge (even if a carry would have occurred), and the step register loads the current settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear and settings load |
| mant_i | input | MANT_W | Rate mantissa M |
| exp_i | input | EXP_W | Rate exponent E |
| tick_o | output | 1 | One-cycle symbol strobe |

## Verification
The bench builds the block with a 4-bit mantissa, a 2-bit exponent and a 12-bit accumulator. A full accumulator period is then only 4096 cycles, so the exact-count property of R2 can be checked over complete periods for several settings, including the largest step of 248. The small widths also put the mid-period settings change, the clear that lands on a carry cycle, and the overflow-encoding equivalence within a few hundred cycles each. The staged-shifter variant is the one built, and every exponent bit is toggled.

// File: rtl/symrate_pkg.sv
package symrate_pkg;

   // Width of the largest step: (2^(mw+1)-1) << (2^ew - 1)
   function automatic int unsigned incr_width(input int unsigned mw, input int unsigned ew);
      return mw + (1 << ew);
   endfunction

endpackage

// File: rtl/symrate_shift.sv
module symrate_shift #(
   parameter int unsigned MANT_W       = 8,
   parameter int unsigned EXP_W        = 4,
   parameter int unsigned INC_W        = 24,
   parameter bit          SHIFT_STAGED = 1'b1
) (
   input  logic [MANT_W-1:0] mant_i,
   input  logic [EXP_W-1:0]  exp_i,
   output logic [INC_W-1:0]  inc_o
);

   localparam int unsigned BASE_W = MANT_W + 1;

   logic [INC_W-1:0] base;
   assign base = INC_W'({1'b1, mant_i});

   generate
      if (SHIFT_STAGED) begin : g_staged
         // logarithmic shifter, one mux rank per exponent bit
         logic [INC_W-1:0] stg [EXP_W+1];
         assign stg[0] = base;
         for (genvar s = 0; s < EXP_W; s++) begin : g_rank
            assign stg[s+1] = exp_i[s] ? (stg[s] << (2 ** s)) : stg[s];
         end
         assign inc_o = stg[EXP_W];
      end else begin : g_direct
         assign inc_o = base << exp_i;
      end
   endgenerate

   if (BASE_W > INC_W) begin : g_bad_width
      $fatal(1, "symrate_shift: INC_W too narrow for mantissa");
   end

endmodule

// File: rtl/symrate_accum.sv
module symrate_accum #(
   parameter int unsigned ACC_W = 28
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             clr_i,
   input  logic [ACC_W-1:0] inc_i,
   output logic [ACC_W-1:0] acc_o,
   output logic             wrap_o,
   output logic             tick_o
);

   logic [ACC_W-1:0] acc_q;
   logic             tick_q;
   logic [ACC_W:0]   sum;

   assign sum    = {1'b0, acc_q} + {1'b0, inc_i};
   assign wrap_o = sum[ACC_W];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         acc_q  <= '0;
         tick_q <= 1'b0;
      end else if (clr_i) begin
         acc_q  <= '0;
         tick_q <= 1'b0;
      end else begin
         acc_q  <= sum[ACC_W-1:0];
         tick_q <= sum[ACC_W];
      end
   end

   assign acc_o  = acc_q;
   assign tick_o = tick_q;

endmodule

// File: rtl/symrate_gen.sv
module symrate_gen #(
   parameter int unsigned MANT_W       = 8,
   parameter int unsigned EXP_W        = 4,
   parameter int unsigned ACC_W        = 28,
   parameter bit          SHIFT_STAGED = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              clr_i,
   input  logic [MANT_W-1:0] mant_i,
   input  logic [EXP_W-1:0]  exp_i,
   output logic              tick_o
);

   localparam int unsigned INC_W = symrate_pkg::incr_width(MANT_W, EXP_W);
   localparam logic [ACC_W-1:0] INC_RST = ACC_W'(1) << MANT_W;

   // elaboration checks: the largest step must not exceed half a period,
   // so that two carries can never fall on adjacent cycles
   if (MANT_W < 1) begin : g_bad_mant
      $fatal(1, "symrate_gen: MANT_W must be at least 1");
   end
   if (EXP_W < 1 || EXP_W > 5) begin : g_bad_exp
      $fatal(1, "symrate_gen: EXP_W must lie in 1..5");
   end
   if (INC_W > ACC_W - 1) begin : g_bad_acc
      $fatal(1, "symrate_gen: ACC_W too narrow for the step range");
   end

   logic [INC_W-1:0] inc_next;
   logic [ACC_W-1:0] inc_q;
   logic [ACC_W-1:0] acc_q;
   logic             wrap;

   symrate_shift #(
      .MANT_W      (MANT_W),
      .EXP_W       (EXP_W),
      .INC_W       (INC_W),
      .SHIFT_STAGED(SHIFT_STAGED)
   ) i_shift (
      .mant_i(mant_i),
      .exp_i (exp_i),
      .inc_o (inc_next)
   );

   // step register: reloads only at a wrap or a clear
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         inc_q <= INC_RST;
      end else if (clr_i || wrap) begin
         inc_q <= ACC_W'(inc_next);
      end
   end

   symrate_accum #(
      .ACC_W(ACC_W)
   ) i_accum (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .clr_i (clr_i),
      .inc_i (inc_q),
      .acc_o (acc_q),
      .wrap_o(wrap),
      .tick_o(tick_o)
   );

endmodule

// File: rtl/symrate_gen_chk.sv
module symrate_gen_chk #(
   parameter int unsigned ACC_W = 28
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             clr_i,
   input logic             tick_o,
   input logic [ACC_W-1:0] acc_q,
   input logic [ACC_W-1:0] inc_q
);

   // R5: strobe never on two consecutive cycles
   p_single_tick_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_o |=> !tick_o);

   // R2 / R5: strobe follows exactly the edges where the phase wrapped
   p_wrap_tick_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !clr_i |=> (tick_o == (acc_q < $past(acc_q))));

   // R7: clear suppresses the strobe
   p_clr_tick_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> !tick_o);

   // R7: clear zeroes the accumulator
   p_clr_acc_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> (acc_q == '0));

   // R6: step changes only with a wrap or after a clear
   p_inc_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(inc_q) |-> ($past(clr_i) || tick_o));

   // R5: step never zero, so phase always advances
   p_inc_nonzero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      inc_q != '0);

endmodule

bind symrate_gen symrate_gen_chk #(.ACC_W(ACC_W)) u_chk (
   .clk_i (clk_i),
   .rst_ni(rst_ni),
   .clr_i (clr_i),
   .tick_o(tick_o),
   .acc_q (acc_q),
   .inc_q (inc_q)
);

// File: tb/test_symrate_gen.sv
`timescale 1ns/1ps
module test_symrate_gen;

   localparam int MW = 4;
   localparam int EW = 2;
   localparam int AW = 12;
   localparam int PERIOD = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          clr = 1'b0;
   logic [MW-1:0] mant = '0;
   logic [EW-1:0] expo = '0;
   logic          tick;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   symrate_gen #(.MANT_W(MW), .EXP_W(EW), .ACC_W(AW), .SHIFT_STAGED(1'b1)) i_symrate_gen (
      .clk_i (clk),
      .rst_ni(rst_n),
      .clr_i (clr),
      .mant_i(mant),
      .exp_i (expo),
      .tick_o(tick)
   );

   function automatic int expect_cnt(input int m, input int e);
      return ((1 << MW) + m) << e;
   endfunction

   task automatic check(input string req, input int act, input int exp_v);
      n_chk++;
      if (act != exp_v) begin
         n_err++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp_v);
      end
   endtask

   // all tasks start and end at a negative edge
   task automatic step(output bit t);
      @(posedge clk);
      @(negedge clk);
      t = tick;
   endtask

   task automatic count_ticks(input int n, output int cnt, output int adj);
      bit t;
      bit prev;
      cnt = 0; adj = 0; prev = 1'b0;
      for (int i = 0; i < n; i++) begin
         step(t);
         if (t) cnt++;
         if (t && prev) adj++;
         prev = t;
      end
   endtask

   task automatic do_clear(input int m, input int e);
      mant = MW'(m); expo = EW'(e); clr = 1'b1;
      @(posedge clk);
      @(negedge clk);
      clr = 1'b0;
   endtask

   task automatic t_reset();
      int c, a;
      bit t;
      mant = 4'd15; expo = 2'd3;
      check("R1 strobe low in reset", int'(tick), 0);
      @(negedge clk);
      rst_n = 1'b1;
      count_ticks(PERIOD / 16 - 1, c, a);
      check("R1 no strobe before first reset-step wrap", c, 0);
      step(t);
      check("R1 first strobe at 256th edge", int'(t), 1);
   endtask

   task automatic t_rates();
      int c, a;
      int ms[4] = '{0, 5, 15, 9};
      int es[4] = '{0, 1, 3, 2};
      for (int k = 0; k < 4; k++) begin
         do_clear(ms[k], es[k]);
         count_ticks(PERIOD, c, a);
         check("R2 strobe count per period", c, expect_cnt(ms[k], es[k]));
      end
   endtask

   task automatic t_double();
      int c0, c1, a;
      do_clear(7, 0);
      count_ticks(PERIOD, c0, a);
      do_clear(7, 1);
      count_ticks(PERIOD, c1, a);
      check("R3 exponent step doubles count", c1, 2 * c0);
   endtask

   task automatic t_equiv();
      int c, a;
      do_clear(0, 1);
      count_ticks(PERIOD, c, a);
      check("R4 M=0,E+1 equals overflowed mantissa", c, (2 << MW) << 0);
   endtask

   task automatic t_single();
      int c, a;
      do_clear(15, 3);
      count_ticks(PERIOD, c, a);
      check("R5 no adjacent strobes at largest step", a, 0);
      check("R5 count at largest step", c, 248);
   endtask

   task automatic t_reload();
      int c, a;
      bit t;
      do_clear(0, 0);
      count_ticks(100, c, a);
      mant = 4'd15; expo = 2'd3;
      count_ticks(155, c, a);
      check("R6 old step still times the period", c, 0);
      step(t);
      check("R6 wrap at old-step edge 256", int'(t), 1);
      count_ticks(16, c, a);
      check("R6 new step quiet for 16 edges", c, 0);
      step(t);
      check("R6 next wrap after 17 edges of new step", int'(t), 1);
   endtask

   task automatic t_clear();
      int c, a;
      bit t;
      do_clear(0, 0);
      count_ticks(255, c, a);
      check("R7 quiet before carry edge", c, 0);
      mant = 4'd0; expo = 2'd1; clr = 1'b1;
      step(t);
      clr = 1'b0;
      check("R7 clear suppresses carry strobe", int'(t), 0);
      count_ticks(127, c, a);
      check("R7 accumulator restarted from zero", c, 0);
      step(t);
      check("R7 clear loaded new step", int'(t), 1);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   endtask

   initial begin
      #(4 * 200000);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      #10;
      t_reset();
      t_rates();
      t_double();
      t_equiv();
      t_single();
      t_reload();
      t_clear();
      finish_run();
   end

endmodule